// File: doc/BRIEF.md
# MSI Capture and Interrupt Aggregator

This block sits inside a root-complex bridge. It watches inbound memory writes and catches those whose 64-bit address equals one of eight programmable capture addresses. The data word of a caught write is a vector index from 0 to 31. It sets that bit in the status word of the matching set. Each set has a per-vector enable mask. An enabled pending vector raises a sticky summary bit for its set in a single top-level status word.

The same top-level word also carries four emulated level interrupts for the legacy lines A to D. Each line is set by an assert message and held until the matching deassert message arrives. One interrupt line goes to the CPU. It is the OR of every top-level status bit whose top-level enable is set. Software reaches all state through a word-addressed register port. Writes take effect at the clock edge. Read data is registered and appears the cycle after the read strobe. An inbound write that cannot be placed sets a sticky error output.

Top module: `msi_intx_agg`

## Requirements
- R1: After reset, every register reads 0 and both `irq_o` and `bad_msi_o` are low.
- R2: Set s holds its capture address in two words: low half at 0xC00+16·s and high half at 0xC80+4·s. A valid inbound write whose address equals {high,low} of an enabled set, with data d < 32, sets bit d of that set's status (offset 0xC00+16·s+4). That bit reads back on the cycle after the write.
- R3: An inbound write is dropped and `bad_msi_o` is set if its data is 32 or more, if its address matches no set, or if the matching set's global enable is 0. No status changes. `bad_msi_o` stays set until reset.
- R4: Writing 1s to a set's status word clears those bits. If an inbound write sets a bit in the same cycle that software clears it, the bit stays set.
- R5: A set's vector mask is at 0xC00+16·s+8. The set is pending when (status & mask) is nonzero and its bit in the global set enable (offset 0x190, bit s) is 1.
- R6: Top-level status (offset 0x184) bit 8+s becomes 1 the cycle after set s is pending. It is cleared by writing 1 to it, and it sets again if the set is still pending.
- R7: Top-level status bits 24..27 are lines A..D. An assert message sets the bit. Writing 1 to it clears it only once a deassert message has arrived. Until then the bit stays 1.
- R8: The top-level enable (offset 0x180) stores only bits 8..15 and 24..27, and other bits read 0. `irq_o` is high exactly when some top-level status bit and its enable bit are both 1.
- R9: When several enabled sets hold the same capture address, only the lowest-numbered one captures.
- R10: Each register reads back what was written, within its implemented bits. Any unmapped offset reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en_i | input | 1 | Register write strobe |
| reg_wr_addr_i | input | 12 | Register write byte offset |
| reg_wr_data_i | input | 32 | Register write data |
| reg_rd_en_i | input | 1 | Register read strobe |
| reg_rd_addr_i | input | 12 | Register read byte offset |
| reg_rd_data_o | output | 32 | Read data, valid the cycle after the strobe |
| msi_valid_i | input | 1 | Inbound memory write valid |
| msi_addr_i | input | 64 | Inbound write address |
| msi_data_i | input | 32 | Inbound write data (vector index) |
| intx_assert_i | input | 4 | Assert message pulses, lines A..D |
| intx_deassert_i | input | 4 | Deassert message pulses, lines A..D |
| irq_o | output | 1 | Combined interrupt to the CPU |
| bad_msi_o | output | 1 | Sticky flag for dropped inbound writes |

## Verification
Two pairs of events can land in the same cycle. The first pair is an inbound capture and a software write-1-to-clear of the same set status bit. The bench drives both strobes on one clock edge for a vector that is already pending, then reads the status back; the bit must survive. The second pair is a clear of a top-level summary bit and a set that is still pending. The bench drains only part of a set before clearing its summary, and the summary must be back on the next read.

// File: rtl/msi_agg_pkg.sv
package msi_agg_pkg;
    localparam int unsigned DATA_W        = 32;
    localparam int unsigned OFF_TOP_EN    = 'h180;
    localparam int unsigned OFF_TOP_ST    = 'h184;
    localparam int unsigned OFF_SET_EN    = 'h190;
    localparam int unsigned OFF_CAP_LO    = 'hC00;
    localparam int unsigned OFF_CAP_HI    = 'hC80;
    localparam int unsigned SET_STRIDE    = 'h10;
    localparam int unsigned HI_STRIDE     = 'h4;
    localparam int unsigned SUB_STATUS    = 'h4;
    localparam int unsigned SUB_MASK      = 'h8;
    localparam int unsigned TOP_MSI_LSB   = 8;
    localparam int unsigned TOP_INTX_LSB  = 24;
endpackage

// File: rtl/msi_set_slice.sv
module msi_set_slice
    import msi_agg_pkg::*;
#(
    parameter int unsigned SET_IDX = 0,
    parameter int unsigned REG_AW  = 12,
    parameter int unsigned VEC_N   = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en_i,
    input  logic [REG_AW-1:0]          wr_addr_i,
    input  logic [DATA_W-1:0]          wr_data_i,
    input  logic                       cap_i,
    input  logic [$clog2(VEC_N)-1:0]   cap_vec_i,
    input  logic                       set_on_i,
    output logic [63:0]                cap_addr_o,
    output logic [VEC_N-1:0]           status_o,
    output logic [VEC_N-1:0]           mask_o,
    output logic                       pend_o
);
    localparam logic [REG_AW-1:0] LO_OFF = REG_AW'(OFF_CAP_LO + SET_IDX * SET_STRIDE);
    localparam logic [REG_AW-1:0] ST_OFF = REG_AW'(OFF_CAP_LO + SET_IDX * SET_STRIDE + SUB_STATUS);
    localparam logic [REG_AW-1:0] MK_OFF = REG_AW'(OFF_CAP_LO + SET_IDX * SET_STRIDE + SUB_MASK);
    localparam logic [REG_AW-1:0] HI_OFF = REG_AW'(OFF_CAP_HI + SET_IDX * HI_STRIDE);

    typedef struct packed {
        logic [31:0]      lo;
        logic [31:0]      hi;
        logic [VEC_N-1:0] status;
        logic [VEC_N-1:0] mask;
    } slice_t;

    slice_t slc_d, slc_q;

    always_comb begin
        logic [VEC_N-1:0] clr;
        logic [VEC_N-1:0] setb;
        slc_d = slc_q;
        clr   = '0;
        setb  = cap_i ? (VEC_N'(1) << cap_vec_i) : '0;
        if (wr_en_i) begin
            if (wr_addr_i == LO_OFF) slc_d.lo   = wr_data_i;
            if (wr_addr_i == HI_OFF) slc_d.hi   = wr_data_i;
            if (wr_addr_i == MK_OFF) slc_d.mask = wr_data_i[VEC_N-1:0];
            if (wr_addr_i == ST_OFF) clr        = wr_data_i[VEC_N-1:0];
        end
        // capture is applied after the clear so a colliding event survives
        slc_d.status = (slc_q.status & ~clr) | setb;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) slc_q <= '0;
        else        slc_q <= slc_d;
    end

    assign cap_addr_o = {slc_q.hi, slc_q.lo};
    assign status_o   = slc_q.status;
    assign mask_o     = slc_q.mask;
    assign pend_o     = set_on_i & (|(slc_q.status & slc_q.mask));
endmodule

// File: rtl/msi_route.sv
module msi_route
    import msi_agg_pkg::*;
#(
    parameter int unsigned NUM_SETS = 8,
    parameter int unsigned VEC_N    = 32
) (
    input  logic                      valid_i,
    input  logic [63:0]               addr_i,
    input  logic [DATA_W-1:0]         data_i,
    input  logic [63:0]               set_addr_i [NUM_SETS],
    input  logic [NUM_SETS-1:0]       set_on_i,
    output logic [NUM_SETS-1:0]       hit_o,
    output logic [$clog2(VEC_N)-1:0]  vec_o,
    output logic                      bad_o
);
    logic                found;
    logic [NUM_SETS-1:0] onehot;
    logic                in_range;

    always_comb begin
        found  = 1'b0;
        onehot = '0;
        for (int s = 0; s < NUM_SETS; s++) begin
            if (!found && set_on_i[s] && (addr_i == set_addr_i[s])) begin
                found     = 1'b1;
                onehot[s] = 1'b1;
            end
        end
    end

    assign in_range = (data_i < DATA_W'(VEC_N));
    assign hit_o    = (valid_i && in_range) ? onehot : '0;
    assign vec_o    = data_i[$clog2(VEC_N)-1:0];
    assign bad_o    = valid_i && (!found || !in_range);
endmodule

// File: rtl/intx_level.sv
module intx_level #(
    parameter int unsigned NUM_INTX = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_INTX-1:0] assert_i,
    input  logic [NUM_INTX-1:0] deassert_i,
    input  logic [NUM_INTX-1:0] clr_i,
    output logic [NUM_INTX-1:0] status_o
);
    typedef struct packed {
        logic [NUM_INTX-1:0] level;
        logic [NUM_INTX-1:0] status;
    } lvl_t;

    lvl_t lv_d, lv_q;

    always_comb begin
        lv_d        = lv_q;
        lv_d.level  = (lv_q.level & ~deassert_i) | assert_i;
        lv_d.status = lv_d.level | (lv_q.status & ~clr_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) lv_q <= '0;
        else        lv_q <= lv_d;
    end

    assign status_o = lv_q.status;
endmodule

// File: rtl/msi_intx_agg.sv
module msi_intx_agg
    import msi_agg_pkg::*;
#(
    parameter int unsigned NUM_SETS = 8,
    parameter int unsigned VEC_N    = 32,
    parameter int unsigned NUM_INTX = 4,
    parameter int unsigned REG_AW   = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr_en_i,
    input  logic [REG_AW-1:0]   reg_wr_addr_i,
    input  logic [31:0]         reg_wr_data_i,
    input  logic                reg_rd_en_i,
    input  logic [REG_AW-1:0]   reg_rd_addr_i,
    output logic [31:0]         reg_rd_data_o,
    input  logic                msi_valid_i,
    input  logic [63:0]         msi_addr_i,
    input  logic [31:0]         msi_data_i,
    input  logic [3:0]          intx_assert_i,
    input  logic [3:0]          intx_deassert_i,
    output logic                irq_o,
    output logic                bad_msi_o
);
    localparam int unsigned VEC_W = $clog2(VEC_N);
    localparam logic [REG_AW-1:0] A_TOP_EN = REG_AW'(OFF_TOP_EN);
    localparam logic [REG_AW-1:0] A_TOP_ST = REG_AW'(OFF_TOP_ST);
    localparam logic [REG_AW-1:0] A_SET_EN = REG_AW'(OFF_SET_EN);

    typedef struct packed {
        logic [NUM_SETS-1:0] ten_msi;
        logic [NUM_INTX-1:0] ten_intx;
        logic [NUM_SETS-1:0] tst_msi;
        logic [NUM_SETS-1:0] set_en;
        logic                bad;
        logic [31:0]         rdata;
    } top_t;

    top_t st_d, st_q;

    logic [63:0]         set_addr   [NUM_SETS];
    logic [VEC_N-1:0]    set_status [NUM_SETS];
    logic [VEC_N-1:0]    set_mask   [NUM_SETS];
    logic [NUM_SETS-1:0] set_pend;
    logic [NUM_SETS-1:0] hit;
    logic [VEC_W-1:0]    vec;
    logic                route_bad;
    logic [NUM_INTX-1:0] intx_st;
    logic [NUM_INTX-1:0] intx_clr;
    logic [31:0]         top_status;
    logic [31:0]         top_enable;
    logic [31:0]         rd_val;
    logic                top_st_wr;

    msi_route #(.NUM_SETS(NUM_SETS), .VEC_N(VEC_N)) u_route (
        .valid_i    (msi_valid_i),
        .addr_i     (msi_addr_i),
        .data_i     (msi_data_i),
        .set_addr_i (set_addr),
        .set_on_i   (st_q.set_en),
        .hit_o      (hit),
        .vec_o      (vec),
        .bad_o      (route_bad)
    );

    for (genvar g = 0; g < NUM_SETS; g++) begin : g_set
        msi_set_slice #(.SET_IDX(g), .REG_AW(REG_AW), .VEC_N(VEC_N)) u_slice (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_en_i    (reg_wr_en_i),
            .wr_addr_i  (reg_wr_addr_i),
            .wr_data_i  (reg_wr_data_i),
            .cap_i      (hit[g]),
            .cap_vec_i  (vec),
            .set_on_i   (st_q.set_en[g]),
            .cap_addr_o (set_addr[g]),
            .status_o   (set_status[g]),
            .mask_o     (set_mask[g]),
            .pend_o     (set_pend[g])
        );
    end

    assign top_st_wr = reg_wr_en_i && (reg_wr_addr_i == A_TOP_ST);
    assign intx_clr  = top_st_wr ? reg_wr_data_i[TOP_INTX_LSB +: NUM_INTX] : '0;

    intx_level #(.NUM_INTX(NUM_INTX)) u_intx (
        .clk        (clk),
        .rst_n      (rst_n),
        .assert_i   (intx_assert_i[NUM_INTX-1:0]),
        .deassert_i (intx_deassert_i[NUM_INTX-1:0]),
        .clr_i      (intx_clr),
        .status_o   (intx_st)
    );

    always_comb begin
        top_status = '0;
        top_enable = '0;
        top_status[TOP_MSI_LSB  +: NUM_SETS] = st_q.tst_msi;
        top_status[TOP_INTX_LSB +: NUM_INTX] = intx_st;
        top_enable[TOP_MSI_LSB  +: NUM_SETS] = st_q.ten_msi;
        top_enable[TOP_INTX_LSB +: NUM_INTX] = st_q.ten_intx;
    end

    always_comb begin
        rd_val = '0;
        if (reg_rd_addr_i == A_TOP_EN) rd_val = top_enable;
        if (reg_rd_addr_i == A_TOP_ST) rd_val = top_status;
        if (reg_rd_addr_i == A_SET_EN) rd_val = 32'(st_q.set_en);
        for (int s = 0; s < NUM_SETS; s++) begin
            if (reg_rd_addr_i == REG_AW'(OFF_CAP_LO + s * SET_STRIDE))
                rd_val = set_addr[s][31:0];
            if (reg_rd_addr_i == REG_AW'(OFF_CAP_LO + s * SET_STRIDE + SUB_STATUS))
                rd_val = 32'(set_status[s]);
            if (reg_rd_addr_i == REG_AW'(OFF_CAP_LO + s * SET_STRIDE + SUB_MASK))
                rd_val = 32'(set_mask[s]);
            if (reg_rd_addr_i == REG_AW'(OFF_CAP_HI + s * HI_STRIDE))
                rd_val = set_addr[s][63:32];
        end
    end

    always_comb begin
        logic [NUM_SETS-1:0] msi_clr;
        st_d    = st_q;
        msi_clr = top_st_wr ? reg_wr_data_i[TOP_MSI_LSB +: NUM_SETS] : '0;
        if (reg_wr_en_i && (reg_wr_addr_i == A_TOP_EN)) begin
            st_d.ten_msi  = reg_wr_data_i[TOP_MSI_LSB  +: NUM_SETS];
            st_d.ten_intx = reg_wr_data_i[TOP_INTX_LSB +: NUM_INTX];
        end
        if (reg_wr_en_i && (reg_wr_addr_i == A_SET_EN))
            st_d.set_en = reg_wr_data_i[NUM_SETS-1:0];
        st_d.tst_msi = (st_q.tst_msi & ~msi_clr) | set_pend;
        st_d.bad     = st_q.bad | route_bad;
        if (reg_rd_en_i) st_d.rdata = rd_val;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign reg_rd_data_o = st_q.rdata;
    assign irq_o         = |(top_status & top_enable);
    assign bad_msi_o     = st_q.bad;
endmodule

// File: rtl/msi_intx_agg_chk.sv
module msi_intx_agg_chk #(
    parameter int unsigned NUM_INTX     = 4,
    parameter int unsigned INTX_LSB     = 24
) (
    input logic        clk,
    input logic        rst_n,
    input logic        msi_valid_i,
    input logic [31:0] msi_data_i,
    input logic [3:0]  intx_assert_i,
    input logic        irq_o,
    input logic        bad_msi_o,
    input logic [31:0] top_st,
    input logic [31:0] top_en
);
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!irq_o && !bad_msi_o)); // R1

    AST_BAD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        bad_msi_o |=> bad_msi_o); // R3

    AST_BAD_ON_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (msi_valid_i && (msi_data_i >= 32'd32)) |=> bad_msi_o); // R3

    AST_INTX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (intx_assert_i[NUM_INTX-1:0] != '0) |=>
        ((top_st[INTX_LSB +: NUM_INTX] & $past(intx_assert_i[NUM_INTX-1:0]))
            == $past(intx_assert_i[NUM_INTX-1:0]))); // R7

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (top_en == 32'd0) |-> !irq_o); // R8
endmodule

bind msi_intx_agg msi_intx_agg_chk #(
    .NUM_INTX (NUM_INTX),
    .INTX_LSB (msi_agg_pkg::TOP_INTX_LSB)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .msi_valid_i   (msi_valid_i),
    .msi_data_i    (msi_data_i),
    .intx_assert_i (intx_assert_i),
    .irq_o         (irq_o),
    .bad_msi_o     (bad_msi_o),
    .top_st        (top_status),
    .top_en        (top_enable)
);

// File: tb/tb_msi_intx_agg.sv
module tb_msi_intx_agg;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [11:0] reg_wr_addr = '0;
    logic [31:0] reg_wr_data = '0;
    logic        reg_rd_en = 1'b0;
    logic [11:0] reg_rd_addr = '0;
    logic [31:0] reg_rd_data;
    logic        msi_valid = 1'b0;
    logic [63:0] msi_addr = '0;
    logic [31:0] msi_data = '0;
    logic [3:0]  intx_assert = '0;
    logic [3:0]  intx_deassert = '0;
    logic        irq;
    logic        bad_msi;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    msi_intx_agg dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .reg_wr_en_i     (reg_wr_en),
        .reg_wr_addr_i   (reg_wr_addr),
        .reg_wr_data_i   (reg_wr_data),
        .reg_rd_en_i     (reg_rd_en),
        .reg_rd_addr_i   (reg_rd_addr),
        .reg_rd_data_o   (reg_rd_data),
        .msi_valid_i     (msi_valid),
        .msi_addr_i      (msi_addr),
        .msi_data_i      (msi_data),
        .intx_assert_i   (intx_assert),
        .intx_deassert_i (intx_deassert),
        .irq_o           (irq),
        .bad_msi_o       (bad_msi)
    );

    function automatic logic [63:0] cap_of(int s);
        return {32'h0000_00A0 + 32'(s), 32'hFEE0_0000 + 32'(s) * 32'h10};
    endfunction
    function automatic logic [11:0] lo_off(int s);  return 12'(12'hC00 + s * 16);     endfunction
    function automatic logic [11:0] st_off(int s);  return 12'(12'hC00 + s * 16 + 4); endfunction
    function automatic logic [11:0] mk_off(int s);  return 12'(12'hC00 + s * 16 + 8); endfunction
    function automatic logic [11:0] hi_off(int s);  return 12'(12'hC80 + s * 4);      endfunction

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd_en = 1'b1; reg_rd_addr = a;
        @(negedge clk);
        reg_rd_en = 1'b0;
        d = reg_rd_data;
    endtask

    task automatic rd_check(string tag, logic [11:0] a, logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        check(tag, v, exp);
    endtask

    task automatic send_msi(logic [63:0] a, logic [31:0] d);
        @(negedge clk);
        msi_valid = 1'b1; msi_addr = a; msi_data = d;
        @(negedge clk);
        msi_valid = 1'b0;
    endtask

    task automatic pulse_intx(logic [3:0] as, logic [3:0] ds);
        @(negedge clk);
        intx_assert = as; intx_deassert = ds;
        @(negedge clk);
        intx_assert = '0; intx_deassert = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        check("R1 irq", 32'(irq), 32'd0);
        check("R1 bad", 32'(bad_msi), 32'd0);
        rd_check("R1 top_en", 12'h180, 32'd0);
        rd_check("R1 top_st", 12'h184, 32'd0);
        rd_check("R1 set_en", 12'h190, 32'd0);
        rd_check("R1 cap_lo0", lo_off(0), 32'd0);
        rd_check("R1 mask7", mk_off(7), 32'd0);

        // R8 / R10: configuration and readback
        wr(12'h180, 32'hFFFF_FFFF);
        rd_check("R8 top_en implemented bits", 12'h180, 32'h0F00_FF00);
        wr(12'h190, 32'h0000_00FF);
        rd_check("R10 set_en", 12'h190, 32'h0000_00FF);
        for (int s = 0; s < 8; s++) begin
            logic [63:0] ca;
            ca = cap_of(s);
            wr(lo_off(s), ca[31:0]);
            wr(hi_off(s), ca[63:32]);
            wr(mk_off(s), 32'hFFFF_FFFF);
            rd_check("R10 cap_lo", lo_off(s), ca[31:0]);
            rd_check("R10 cap_hi", hi_off(s), ca[63:32]);
        end
        rd_check("R10 unmapped", 12'h104, 32'd0);
        check("R8 irq idle", 32'(irq), 32'd0);

        // R2 / R6 / R8: exhaustive sweep of every set and vector
        for (int s = 0; s < 8; s++) begin
            for (int v = 0; v < 32; v++) begin
                send_msi(cap_of(s), 32'(v));
                rd_check("R2 set status", st_off(s), 32'd1 << v);
                rd_check("R6 top summary", 12'h184, 32'd1 << (8 + s));
                check("R8 irq on", 32'(irq), 32'd1);
                wr(st_off(s), 32'd1 << v);
                wr(12'h184, 32'd1 << (8 + s));
                rd_check("R6 summary cleared", 12'h184, 32'd0);
                check("R8 irq off", 32'(irq), 32'd0);
            end
        end

        // R5: vector mask gates the summary
        wr(mk_off(2), 32'd0);
        send_msi(cap_of(2), 32'd5);
        rd_check("R5 status unmasked view", st_off(2), 32'd1 << 5);
        rd_check("R5 masked summary", 12'h184, 32'd0);
        check("R5 masked irq", 32'(irq), 32'd0);
        wr(mk_off(2), 32'd1 << 5);
        rd_check("R5 enabled summary", 12'h184, 32'd1 << 10);
        wr(st_off(2), 32'hFFFF_FFFF);
        wr(12'h184, 32'h0000_FF00);
        wr(mk_off(2), 32'hFFFF_FFFF);
        rd_check("R5 cleanup", 12'h184, 32'd0);

        // R6: summary re-asserts while a vector is still pending
        send_msi(cap_of(1), 32'd3);
        send_msi(cap_of(1), 32'd4);
        rd_check("R6 two pending", st_off(1), 32'h18);
        wr(st_off(1), 32'h8);
        wr(12'h184, 32'd1 << 9);
        rd_check("R6 reassert", 12'h184, 32'd1 << 9);
        wr(st_off(1), 32'h10);
        wr(12'h184, 32'd1 << 9);
        rd_check("R6 drained", 12'h184, 32'd0);

        // R4: capture and clear of the same bit in one cycle
        send_msi(cap_of(0), 32'd7);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_addr = st_off(0); reg_wr_data = 32'd1 << 7;
        msi_valid = 1'b1; msi_addr = cap_of(0); msi_data = 32'd7;
        @(negedge clk);
        reg_wr_en = 1'b0; msi_valid = 1'b0;
        rd_check("R4 capture wins", st_off(0), 32'd1 << 7);
        wr(st_off(0), 32'd1 << 7);
        rd_check("R4 plain clear", st_off(0), 32'd0);
        wr(12'h184, 32'h0000_FF00);

        // R7: emulated level lines
        for (int i = 0; i < 4; i++) begin
            pulse_intx(4'(1 << i), 4'd0);
            rd_check("R7 asserted", 12'h184, 32'd1 << (24 + i));
            check("R7 irq", 32'(irq), 32'd1);
            wr(12'h184, 32'd1 << (24 + i));
            rd_check("R7 clear before deassert", 12'h184, 32'd1 << (24 + i));
            pulse_intx(4'd0, 4'(1 << i));
            rd_check("R7 held after deassert", 12'h184, 32'd1 << (24 + i));
            wr(12'h184, 32'd1 << (24 + i));
            rd_check("R7 cleared", 12'h184, 32'd0);
            check("R7 irq off", 32'(irq), 32'd0);
        end

        // R9: duplicate address, lowest set wins
        wr(lo_off(6), cap_of(4)[31:0]);
        wr(hi_off(6), cap_of(4)[63:32]);
        send_msi(cap_of(4), 32'd9);
        rd_check("R9 low set captures", st_off(4), 32'd1 << 9);
        rd_check("R9 high set untouched", st_off(6), 32'd0);
        wr(st_off(4), 32'hFFFF_FFFF);
        wr(12'h184, 32'h0000_FF00);

        // R3: dropped inbound writes
        check("R3 flag clear so far", 32'(bad_msi), 32'd0);
        send_msi(cap_of(0), 32'd32);
        check("R3 flag on data range", 32'(bad_msi), 32'd1);
        rd_check("R3 no capture range", st_off(0), 32'd0);
        send_msi(64'h1234_5678_0000_0000, 32'd1);
        rd_check("R3 no capture unmatched", st_off(0), 32'd0);
        wr(12'h190, 32'h0000_00F7);
        send_msi(cap_of(3), 32'd1);
        rd_check("R3 disabled set", st_off(3), 32'd0);
        check("R3 flag sticky", 32'(bad_msi), 32'd1);
        rd_check("R3 no summary", 12'h184, 32'd0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule